// File: doc/BRIEF.md
# Pipelined Multiply / Barrel-Shift Datapath

This unit takes two operands and produces either their full-width product or a shifted or rotated copy of the first operand. The second operand supplies the shift distance. Three control inputs choose the operation: multiply or shift, left or right, and shift or rotate. Each operand has its own signedness flag. The flags allow signed, unsigned and mixed-sign products. The flag on the first operand also selects arithmetic rather than logical right shifts.

The combinational result goes through two register stages, and each stage has its own load enable. A flag marking multiply-mode results travels with the data through both stages. An asynchronous active-high reset clears both stages. The operand width is a parameter; the default is 32 bits, which gives a 64-bit result.

Internally the control inputs are decoded into one of six named operations: OP_MUL, OP_SHL, OP_SHR, OP_SAR, OP_ROL and OP_ROR. The pipeline has no state machine beyond its two data stages.

Top module: `mulshf_unit`

## Requirements
- R1: While `rst` is 1, `result` and `result_mul` are 0, without waiting for a clock edge.
- R2: With `do_shift`=0, the result is the low 2W bits of the product of the two operands. An operand whose flag is 0 is treated as unsigned.
- R3: With `do_shift`=0, an operand whose flag is 1 is treated as two's-complement. Signed×unsigned, unsigned×signed and signed×signed products are all exact in the low 2W bits.
- R4: With `do_shift`=1, `linear`=1, `go_right`=1 and `a_signed`=0, the result is `opa` shifted right with zero fill.
- R5: With `do_shift`=1, `linear`=1, `go_right`=1 and `a_signed`=1, the result is `opa` shifted right with copies of its top bit.
- R6: With `do_shift`=1, `linear`=1 and `go_right`=0, the result is `opa` shifted left with zero fill, whatever `a_signed` is.
- R7: With `do_shift`=1, `linear`=0 and `go_right`=1, the result is `opa` rotated right. Bits leaving bit 0 re-enter at bit W-1.
- R8: With `do_shift`=1, `linear`=0 and `go_right`=0, the result is `opa` rotated left.
- R9: In every shift and rotate operation, the upper W bits of `result` are 0.
- R10: The shift distance is the low log2(W) bits of `opb`. Higher bits of `opb` have no effect in shift or rotate operations.
- R11: Stage one loads the new result on a clock edge where `en_in`=1. Stage two copies stage one on a clock edge where `en_out`=1. A stage whose enable is 0 holds its value. The two enables are independent.
- R12: `result_mul` is 1 exactly when the value on `result` was produced in multiply mode. It moves through both stages under the same enables as the data.
- R13: A shift distance of 0 returns `opa` unchanged in all four shift and rotate operations.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Asynchronous reset, active high |
| en_in | input | 1 | Load enable of stage one |
| en_out | input | 1 | Load enable of stage two |
| opa | input | W | First operand; also the value that is shifted |
| opb | input | W | Second operand; its low bits give the shift distance |
| a_signed | input | 1 | `opa` is two's-complement; selects arithmetic right shift |
| b_signed | input | 1 | `opb` is two's-complement for multiply |
| do_shift | input | 1 | 1 = shift or rotate, 0 = multiply |
| go_right | input | 1 | 1 = right, 0 = left |
| linear | input | 1 | 1 = shift, 0 = rotate |
| result | output | 2W | Output of stage two |
| result_mul | output | 1 | Stage-two flag: result came from multiply mode |

## Verification
The bench runs the unit with 8-bit operands so that every shift distance can be swept.

- **Shift and rotate sweeps.** Every distance from 0 to 7 is applied in each shift and rotate mode. The operands have the top bit set and clear, which separates sign fill from zero fill and rotation from plain shifting.
- **Junk in the upper bits of `opb`.** Some sweeps put garbage in the upper bits of `opb`. This shows whether those bits leak into the shift distance.
- **Multiply grid.** A stepped grid of multiplier operands is applied under all four sign-flag combinations. This separates true sign extension from zero extension.
- **Random run.** A long random run toggles both enables independently every cycle. It catches a stage that loads when its enable is low, or skips a stage.

// File: rtl/mulshf_pkg.sv
package mulshf_pkg;

    typedef enum logic [2:0] {
        OP_MUL = 3'd0,
        OP_SHL = 3'd1,
        OP_SHR = 3'd2,
        OP_SAR = 3'd3,
        OP_ROL = 3'd4,
        OP_ROR = 3'd5
    } op_e;

    function automatic op_e op_decode(input logic do_shift, input logic go_right,
                                      input logic linear, input logic a_signed);
        op_e r;
        if (!do_shift)      r = OP_MUL;
        else if (!linear)   r = go_right ? OP_ROR : OP_ROL;
        else if (!go_right) r = OP_SHL;
        else                r = a_signed ? OP_SAR : OP_SHR;
        return r;
    endfunction

endpackage

// File: rtl/mulshf_mult.sv
module mulshf_mult #(
    parameter int W = 32
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic           a_sgn,
    input  logic           b_sgn,
    output logic [2*W-1:0] prod
);
    localparam int PW = 2 * W;

    logic [PW-1:0] ext_a, ext_b;

    // Widening to the product width gives the same low 2W bits as a
    // one-bit extension followed by truncation.
    always_comb begin
        ext_a = {{W{a_sgn & a[W-1]}}, a};
        ext_b = {{W{b_sgn & b[W-1]}}, b};
        prod  = ext_a * ext_b;
    end
endmodule

// File: rtl/mulshf_shift.sv
module mulshf_shift
    import mulshf_pkg::*;
#(
    parameter int W   = 32,
    parameter int SHW = $clog2(W)
) (
    input  op_e            op,
    input  logic [W-1:0]   x,
    input  logic [SHW-1:0] amt,
    output logic [W-1:0]   y
);
    logic [2*W-1:0] dbl, rot;

    always_comb begin
        dbl = {x, x};
        rot = (op == OP_ROR) ? (dbl >> amt) : (dbl << amt);
        y   = '0;
        unique case (op)
            OP_SHL:  y = x << amt;
            OP_SHR:  y = x >> amt;
            OP_SAR:  y = $signed(x) >>> amt;
            OP_ROR:  y = rot[W-1:0];
            OP_ROL:  y = rot[2*W-1:W];
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/mulshf_stage.sv
module mulshf_stage #(
    parameter int DW = 65
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [DW-1:0] d,
    output logic [DW-1:0] q
);
    always_ff @(posedge clk or posedge rst) begin
        if (rst)     q <= '0;
        else if (en) q <= d;
    end
endmodule

// File: rtl/mulshf_unit.sv
module mulshf_unit
    import mulshf_pkg::*;
#(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           en_in,
    input  logic           en_out,
    input  logic [W-1:0]   opa,
    input  logic [W-1:0]   opb,
    input  logic           a_signed,
    input  logic           b_signed,
    input  logic           do_shift,
    input  logic           go_right,
    input  logic           linear,
    output logic [2*W-1:0] result,
    output logic           result_mul
);
    localparam int SHW = $clog2(W);
    localparam int RW  = 2 * W;
    localparam int SW  = RW + 1;

    op_e           op;
    logic [RW-1:0] prod;
    logic [W-1:0]  shf;
    logic [RW-1:0] comb_val;
    logic [SW-1:0] s1_q, s2_q;

    assign op = op_decode(do_shift, go_right, linear, a_signed);

    mulshf_mult #(.W(W)) u_mult (
        .a(opa), .b(opb), .a_sgn(a_signed), .b_sgn(b_signed), .prod(prod)
    );

    mulshf_shift #(.W(W), .SHW(SHW)) u_shift (
        .op(op), .x(opa), .amt(opb[SHW-1:0]), .y(shf)
    );

    always_comb begin
        unique case (op)
            OP_MUL:  comb_val = prod;
            default: comb_val = {{W{1'b0}}, shf};
        endcase
    end

    mulshf_stage #(.DW(SW)) u_s1 (
        .clk(clk), .rst(rst), .en(en_in), .d({op == OP_MUL, comb_val}), .q(s1_q)
    );

    mulshf_stage #(.DW(SW)) u_s2 (
        .clk(clk), .rst(rst), .en(en_out), .d(s1_q), .q(s2_q)
    );

    assign result     = s2_q[RW-1:0];
    assign result_mul = s2_q[RW];
endmodule

// File: rtl/mulshf_unit_chk.sv
module mulshf_unit_chk #(
    parameter int W = 32
) (
    input logic           clk,
    input logic           rst,
    input logic           en_in,
    input logic           en_out,
    input logic           do_shift,
    input logic           go_right,
    input logic           linear,
    input logic [W-1:0]   opb,
    input logic [2*W:0]   s1_q,
    input logic [2*W-1:0] result,
    input logic           result_mul
);
    localparam int SHW = $clog2(W);

    p_reset_clear_r1: assert property (@(negedge clk)
        rst |-> (result == '0 && !result_mul));

    p_hold_out_r11: assert property (@(posedge clk) disable iff (rst)
        !en_out |=> ($stable(result) && $stable(result_mul)));

    p_copy_out_r11: assert property (@(posedge clk) disable iff (rst)
        en_out |=> ({result_mul, result} == $past(s1_q)));

    p_upper_zero_r9: assert property (@(posedge clk) disable iff (rst)
        !result_mul |-> (result[2*W-1:W] == '0));

    p_tag_load_r12: assert property (@(posedge clk) disable iff (rst)
        en_in |=> (s1_q[2*W] == $past(!do_shift)));

    p_left_fill_r6: assert property (@(posedge clk) disable iff (rst)
        (en_in && do_shift && linear && !go_right && opb[SHW-1:0] != '0)
        |=> (s1_q[0] == 1'b0));
endmodule

bind mulshf_unit mulshf_unit_chk #(.W(W)) u_chk (
    .clk(clk), .rst(rst), .en_in(en_in), .en_out(en_out),
    .do_shift(do_shift), .go_right(go_right), .linear(linear), .opb(opb),
    .s1_q(s1_q), .result(result), .result_mul(result_mul)
);

// File: tb/mulshf_unit_tb.sv
module mulshf_unit_tb;
    localparam int W      = 8;
    localparam int RW     = 2 * W;
    localparam int SHW    = 3;
    localparam int PERIOD = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          en_in = 1'b0, en_out = 1'b0;
    logic [W-1:0]  opa = '0, opb = '0;
    logic          a_signed = 1'b0, b_signed = 1'b0;
    logic          do_shift = 1'b0, go_right = 1'b0, linear = 1'b0;
    logic [RW-1:0] result;
    logic          result_mul;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    logic [RW-1:0] m1 = '0, m2 = '0;
    logic          t1 = 1'b0, t2 = 1'b0;

    mulshf_unit #(.W(W)) u_dut (
        .clk(clk), .rst(rst), .en_in(en_in), .en_out(en_out),
        .opa(opa), .opb(opb), .a_signed(a_signed), .b_signed(b_signed),
        .do_shift(do_shift), .go_right(go_right), .linear(linear),
        .result(result), .result_mul(result_mul)
    );

    always #(PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc++;

    function automatic logic [RW-1:0] ref_val(
        input logic [W-1:0] a, input logic [W-1:0] b, input logic as, input logic bs,
        input logic sh, input logic dr, input logic ln);
        longint va, vb;
        logic [W-1:0] y;
        int amt;
        if (!sh) begin
            va = (as && a[W-1]) ? longint'(a) - (longint'(1) << W) : longint'(a);
            vb = (bs && b[W-1]) ? longint'(b) - (longint'(1) << W) : longint'(b);
            return RW'(va * vb);
        end
        amt = int'(b) % W;
        for (int i = 0; i < W; i++) begin
            if (!ln && dr)      y[i] = a[(i + amt) % W];
            else if (!ln)       y[i] = a[(i - amt + W) % W];
            else if (!dr)       y[i] = (i >= amt) ? a[i - amt] : 1'b0;
            else if (i + amt < W) y[i] = a[i + amt];
            else                y[i] = as ? a[W-1] : 1'b0;
        end
        return {{W{1'b0}}, y};
    endfunction

    task automatic check(input string req, input logic [RW-1:0] act, input logic [RW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s cycle %0d: actual=%h expected=%h", req, cyc, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        if (en_out) begin m2 = m1; t2 = t1; end
        if (en_in) begin
            m1 = ref_val(opa, opb, a_signed, b_signed, do_shift, go_right, linear);
            t1 = !do_shift;
        end
        @(negedge clk);
    endtask

    task automatic run_op(input string req, input logic [W-1:0] a, input logic [W-1:0] b,
                          input logic as, input logic bs, input logic sh,
                          input logic dr, input logic ln);
        opa = a; opb = b; a_signed = as; b_signed = bs;
        do_shift = sh; go_right = dr; linear = ln;
        en_in = 1'b1; en_out = 1'b1;
        step();
        step();
        check(req, result, m2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog cycle %0d: actual=running expected=finished", cyc);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        check("R1", {result_mul, result[RW-2:0]}, '0);
        @(negedge clk);
        rst = 1'b0;

        // R4 R5 R6 R7 R8 R13: every distance; R10: junk in upper opb bits
        for (int d = 0; d < W; d++) begin
            logic [W-1:0] b;
            b = W'(d) | (W'(d * 37) & ~W'((1 << SHW) - 1));
            run_op("R4", 8'hB5, b, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
            run_op("R5", 8'hB5, b, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1);
            run_op("R5", 8'h4D, b, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1);
            run_op("R6", 8'hC3, b, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
            run_op("R7", 8'h96, b, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
            run_op("R8", 8'h96, b, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
            check("R9", {8'h00, result[W-1:0]}, result);
            run_op("R10", 8'h96, W'(d) | 8'hF8, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
            check("R10", result, ref_val(8'h96, W'(d), 1'b0, 1'b0, 1'b1, 1'b0, 1'b0));
        end
        for (int m = 0; m < 4; m++) begin
            run_op("R13", 8'hA7, 8'h08, 1'b1, 1'b0, 1'b1, m[0], m[1]);
            check("R13", result, 16'h00A7);
        end

        // R2 R3 multiply grid under all sign combinations
        for (int s = 0; s < 4; s++)
            for (int i = 0; i < 256; i += 37)
                for (int j = 0; j < 256; j += 29)
                    run_op(s == 0 ? "R2" : "R3", W'(i), W'(j), s[0], s[1], 1'b0, 1'b0, 1'b0);
        run_op("R3", 8'hFF, 8'hFF, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R3", result, 16'hFF01);
        check("R12", {15'b0, result_mul}, 16'h0001);
        run_op("R12", 8'h80, 8'h01, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
        check("R12", {15'b0, result_mul}, 16'h0000);

        // R11 hold: stage two disabled, new inputs must not reach output
        en_out = 1'b0; opa = 8'h11; opb = 8'h22; do_shift = 1'b0;
        begin
            logic [RW-1:0] held;
            held = result;
            step();
            step();
            check("R11", result, held);
        end

        // R11 R12 random enables and modes
        for (int n = 0; n < 20000; n++) begin
            {opa, opb} = RW'($urandom);
            {a_signed, b_signed, do_shift, go_right, linear, en_in, en_out} = 7'($urandom);
            step();
            check("R11", result, m2);
            check("R12", {15'b0, result_mul}, {15'b0, t2});
        end

        // R1 asynchronous clear mid-run
        en_in = 1'b1; en_out = 1'b1;
        run_op("R2", 8'hF0, 8'h0F, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        #1 rst = 1'b1;
        #1 check("R1", {result_mul, result[RW-2:0]}, '0);
        m1 = '0; m2 = '0; t1 = 1'b0; t2 = 1'b0;
        @(negedge clk);
        rst = 1'b0;

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule